// File: doc/BRIEF.md
# Byte-Reversing Indexed Word Store Unit

This block is a small execute stage for a single instruction: an indexed word store that writes the low 32 bits of a general-purpose register to memory with its four bytes in reverse order. It takes a 32-bit instruction word with a valid strobe and checks the opcode fields. It names three registers (data source, base and index) on a combinational register-read interface. From these it forms the effective address. It then issues one write on a 32-bit memory port and advances its program counter once the memory acknowledges the write.

The block also holds a load-reservation register. An external load-reserve path sets it with an address. When tracking is enabled, a store into the same 32-byte granule clears it, no later than the clock edge where the write appears on the memory port. An instruction word that does not match the opcode fields causes no write. It raises an illegal-instruction flag for one cycle.

Top module: `brstore_unit`

## Requirements
- R1: An instruction is accepted as the store when bits 31:26 of the word equal 31 and bits 10:1 equal 662, with bit 0 ignored. Bit 31 is the most significant bit, which is opcode bit 0 in big-endian numbering. The canonical word is 0x7C00052C.
- R2: The register-read addresses come from the word: the source register from bits 25:21, the base register from bits 20:16 and the index register from bits 15:11. The base read enable is low whenever the base field is 0.
- R3: The effective address is the low 32 bits of the 64-bit wrapping sum of base and index.
- R4: When the base field is 0, the base operand is zero and register 0's value has no effect, so the address equals the low 32 bits of the index register.
- R5: The write data is the source register's low word with its bytes reversed. The byte that lands at the effective address sits in `mem_wdata[31:24]`, and `mem_wdata[31:24]` carries source bits 7:0. The upper 32 source bits have no effect. `mem_be` is 4'b1111.
- R6: `mem_we` is high for exactly one cycle, in the cycle after the store is accepted. `done` pulses for one cycle, in the cycle after the first edge where `mem_ready` is sampled high while the store is pending. `mem_ready` may be sampled from the cycle that has `mem_we` high onward.
- R7: The program counter grows by 4 in the cycle when `done` goes high. It changes at no other time and starts at `RESET_PC`.
- R8: When `resv_en` is high and a store is accepted whose address bits 31:5 equal the held reservation address, `resv_valid` is low from the same edge that raises `mem_we`. On any other address, or with `resv_en` low, `resv_valid` is unchanged. A `resv_set` in the same cycle takes precedence.
- R9: A non-matching instruction with `insn_valid` high and the unit idle produces no write, no reservation change and no program-counter change. It raises `illegal` for one cycle, in the cycle after acceptance.
- R10: While a store is pending (`busy` high), `insn_valid` is ignored.
- R11: Unaligned effective addresses are issued as computed, and no fault is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | Instruction word present |
| insn_word | input | 32 | Instruction word |
| busy | output | 1 | A store is pending |
| done | output | 1 | Store completed (one-cycle pulse) |
| illegal | output | 1 | Non-matching instruction (one-cycle pulse) |
| pc | output | 64 | Program counter |
| rf_src_addr | output | 5 | Source register number |
| rf_base_addr | output | 5 | Base register number |
| rf_base_re | output | 1 | Base register read enable |
| rf_idx_addr | output | 5 | Index register number |
| rf_src_data | input | 64 | Source register value |
| rf_base_data | input | 64 | Base register value |
| rf_idx_data | input | 64 | Index register value |
| mem_we | output | 1 | Write strobe, one cycle |
| mem_addr | output | 32 | Write byte address |
| mem_wdata | output | 32 | Write data, byte at address in bits 31:24 |
| mem_be | output | 4 | Byte enables |
| mem_ready | input | 1 | Write acknowledge |
| resv_en | input | 1 | Reservation tracking enabled |
| resv_set | input | 1 | Establish a reservation |
| resv_addr | input | 32 | Address to reserve |
| resv_valid | output | 1 | Reservation held |

## Verification
A wrong captured address or byte order shows on `mem_addr`/`mem_wdata` in the cycle right after acceptance, together with the single `mem_we` pulse. A corrupted reservation granule compare shows on `resv_valid` at that same edge. A stuck or wrongly sequenced pending state shows as a missing, early or repeated `done`, or as a second write pulse while a later instruction is presented. An error in the program-counter increment shows on `pc` in the `done` cycle. An error in decoding shows as `illegal` rising for a valid store, or as a write for a foreign word, one cycle after presentation.

// File: rtl/brstore_pkg.sv
package brstore_pkg;
    localparam int unsigned INSN_W    = 32;
    localparam int unsigned REGSEL_W  = 5;
    localparam logic [5:0]  PRIMARY_OP = 6'd31;
    localparam logic [9:0]  EXTEND_OP  = 10'd662;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } brst_state_e;

    typedef struct packed {
        logic                is_store;
        logic [REGSEL_W-1:0] src_sel;
        logic [REGSEL_W-1:0] base_sel;
        logic [REGSEL_W-1:0] idx_sel;
        logic                base_zero;
    } brst_dec_t;
endpackage

// File: rtl/brst_decode.sv
module brst_decode
    import brstore_pkg::*;
(
    input  logic [INSN_W-1:0] word_i,
    output brst_dec_t         dec_o
);
    always_comb begin
        dec_o.is_store  = (word_i[31:26] == PRIMARY_OP) && (word_i[10:1] == EXTEND_OP);
        dec_o.src_sel   = word_i[25:21];
        dec_o.base_sel  = word_i[20:16];
        dec_o.idx_sel   = word_i[15:11];
        dec_o.base_zero = (word_i[20:16] == '0);
    end
endmodule

// File: rtl/brst_agen.sv
module brst_agen #(
    parameter int unsigned XLEN = 64,
    parameter int unsigned AW   = 32,
    parameter int unsigned DW   = 32
) (
    input  logic            base_zero_i,
    input  logic [XLEN-1:0] base_i,
    input  logic [XLEN-1:0] idx_i,
    input  logic [XLEN-1:0] src_i,
    output logic [AW-1:0]   ea_o,
    output logic [DW-1:0]   data_o
);
    localparam int unsigned NBYTES = DW / 8;

    logic [XLEN-1:0] base_eff;
    logic [XLEN-1:0] sum;

    always_comb begin
        base_eff = base_zero_i ? '0 : base_i;
        sum      = base_eff + idx_i;
        ea_o     = sum[AW-1:0];
    end

    for (genvar b = 0; b < NBYTES; b++) begin : g_swap
        assign data_o[DW-1-8*b -: 8] = src_i[8*b +: 8];
    end
endmodule

// File: rtl/brstore_unit.sv
module brstore_unit
    import brstore_pkg::*;
#(
    parameter int unsigned XLEN        = 64,
    parameter int unsigned AW          = 32,
    parameter int unsigned DW          = 32,
    parameter int unsigned GRANULE_LG  = 5,
    parameter logic [63:0] RESET_PC    = 64'h100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                insn_valid,
    input  logic [INSN_W-1:0]   insn_word,
    output logic                busy,
    output logic                done,
    output logic                illegal,
    output logic [XLEN-1:0]     pc,
    output logic [REGSEL_W-1:0] rf_src_addr,
    output logic [REGSEL_W-1:0] rf_base_addr,
    output logic                rf_base_re,
    output logic [REGSEL_W-1:0] rf_idx_addr,
    input  logic [XLEN-1:0]     rf_src_data,
    input  logic [XLEN-1:0]     rf_base_data,
    input  logic [XLEN-1:0]     rf_idx_data,
    output logic                mem_we,
    output logic [AW-1:0]       mem_addr,
    output logic [DW-1:0]       mem_wdata,
    output logic [DW/8-1:0]     mem_be,
    input  logic                mem_ready,
    input  logic                resv_en,
    input  logic                resv_set,
    input  logic [AW-1:0]       resv_addr,
    output logic                resv_valid
);
    localparam int unsigned TAG_W = AW - GRANULE_LG;

    typedef struct packed {
        brst_state_e      st;
        logic [AW-1:0]    ea;
        logic [DW-1:0]    wdata;
        logic             we;
        logic             done;
        logic             ill;
        logic [XLEN-1:0]  pc;
        logic             rv;
        logic [TAG_W-1:0] rtag;
    } brst_regs_t;

    brst_regs_t q, d;
    brst_dec_t  dec;
    logic [AW-1:0] ea_c;
    logic [DW-1:0] data_c;
    logic          accept;

    brst_decode u_dec (
        .word_i (insn_word),
        .dec_o  (dec)
    );

    brst_agen #(.XLEN(XLEN), .AW(AW), .DW(DW)) u_agen (
        .base_zero_i (dec.base_zero),
        .base_i      (rf_base_data),
        .idx_i       (rf_idx_data),
        .src_i       (rf_src_data),
        .ea_o        (ea_c),
        .data_o      (data_c)
    );

    assign accept = insn_valid && (q.st == ST_IDLE);

    always_comb begin
        d      = q;
        d.we   = 1'b0;
        d.done = 1'b0;
        d.ill  = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (accept) begin
                    if (dec.is_store) begin
                        d.ea    = ea_c;
                        d.wdata = data_c;
                        d.we    = 1'b1;
                        d.st    = ST_BUSY;
                        if (resv_en && q.rv && (ea_c[AW-1:GRANULE_LG] == q.rtag))
                            d.rv = 1'b0;
                    end else begin
                        d.ill = 1'b1;
                    end
                end
            end
            default: begin
                if (mem_ready) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                    d.pc   = q.pc + XLEN'(4);
                end
            end
        endcase
        if (resv_set) begin
            d.rv   = 1'b1;
            d.rtag = resv_addr[AW-1:GRANULE_LG];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st    <= ST_IDLE;
            q.ea    <= '0;
            q.wdata <= '0;
            q.we    <= 1'b0;
            q.done  <= 1'b0;
            q.ill   <= 1'b0;
            q.pc    <= RESET_PC[XLEN-1:0];
            q.rv    <= 1'b0;
            q.rtag  <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy         = (q.st == ST_BUSY);
    assign done         = q.done;
    assign illegal      = q.ill;
    assign pc           = q.pc;
    assign rf_src_addr  = dec.src_sel;
    assign rf_base_addr = dec.base_sel;
    assign rf_idx_addr  = dec.idx_sel;
    assign rf_base_re   = insn_valid && dec.is_store && !dec.base_zero;
    assign mem_we       = q.we;
    assign mem_addr     = q.ea;
    assign mem_wdata    = q.wdata;
    assign mem_be       = '1;
    assign resv_valid   = q.rv;

    assert_base_re_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_word[20:16] == 5'd0) |-> !rf_base_re);

    assert_we_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    assert_done_after_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(mem_ready) && $past(busy)));

    assert_pc_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pc == $past(pc) + XLEN'(4)));

    assert_pc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(pc));

    assert_swap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> (mem_wdata[31:24] == $past(rf_src_data[7:0]) &&
                           mem_wdata[7:0]   == $past(rf_src_data[31:24])));

    assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!mem_we && !busy));

    assert_resv_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_we) && $past(resv_en && resv_valid && !resv_set) &&
         $past(resv_valid) && (mem_addr[AW-1:GRANULE_LG] == $past(q.rtag)))
        |-> !resv_valid);

    assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_ready) |=> (busy && !illegal && !mem_we));
endmodule

// File: tb/brstore_unit_tb.sv
`timescale 1ns/1ps
module brstore_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 1'b0;
    logic [31:0] insn_word = '0;
    logic        busy, done, illegal;
    logic [63:0] pc;
    logic [4:0]  rf_src_addr, rf_base_addr, rf_idx_addr;
    logic        rf_base_re;
    logic [63:0] rf_src_data, rf_base_data, rf_idx_data;
    logic        mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic        mem_ready = 1'b0;
    logic        resv_en = 1'b0, resv_set = 1'b0;
    logic [31:0] resv_addr = '0;
    logic        resv_valid;

    logic [63:0] rf [32];
    int n_chk = 0, n_fail = 0, n_we = 0;
    bit  finished = 0;

    always #2 clk = ~clk;

    assign rf_src_data  = rf[rf_src_addr];
    assign rf_base_data = rf[rf_base_addr];
    assign rf_idx_data  = rf[rf_idx_addr];

    always @(negedge clk) if (rst_n && mem_we) n_we++;

    brstore_unit u_dut (.*);

    function automatic logic [31:0] mk(input logic [4:0] s, a, b, input bit rc);
        return 32'h7C00052C | (32'(s) << 21) | (32'(a) << 16) | (32'(b) << 11) | 32'(rc);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    typedef struct packed {
        logic [4:0]  s, a, b;
        logic        rc;
        logic [63:0] sv, bv, iv;
        logic [31:0] ea, dat;
        logic [3:0]  lat;
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{5'd3, 5'd4, 5'd5, 1'b0, 64'hFFFF_FFFF_1122_3344, 64'h1000, 64'h20, 32'h0000_1020, 32'h4433_2211, 4'd0},
        '{5'd1, 5'd0, 5'd7, 1'b0, 64'h0000_0000_A1B2_C3D4, 64'h0, 64'h0000_0000_DEAD_BEEC, 32'hDEAD_BEEC, 32'hD4C3_B2A1, 4'd2},
        '{5'd2, 5'd6, 5'd8, 1'b0, 64'h0000_0000_1234_5678, 64'hFFFF_FFFF_FFFF_FFF0, 64'h20, 32'h0000_0010, 32'h7856_3412, 4'd1},
        '{5'd9, 5'd10, 5'd11, 1'b1, 64'hCAFE_BABE_00FF_0080, 64'h0000_0001_0000_0000, 64'h3, 32'h0000_0003, 32'h8000_FF00, 4'd3},
        '{5'd0, 5'd31, 5'd30, 1'b0, 64'h0000_0000_0000_5555, 64'h100, 64'h7, 32'h0000_0107, 32'h5555_0000, 4'd0}
    };

    // Present one word, check the write beat, then the handshake and completion.
    task automatic run_store(input logic [31:0] w, input int lat,
                             input logic [31:0] ea, input logic [31:0] dat, input string tag);
        logic [63:0] pc0;
        pc0 = pc;
        @(negedge clk);
        insn_word = w; insn_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        insn_valid = 1'b0;
        chk(mem_we == 1'b1, "R6", {tag, " we"}, 64'(mem_we), 64'd1);
        chk(mem_addr == ea, "R3", {tag, " addr"}, 64'(mem_addr), 64'(ea));
        chk(mem_wdata == dat, "R5", {tag, " data"}, 64'(mem_wdata), 64'(dat));
        chk(mem_be == 4'hF, "R5", {tag, " be"}, 64'(mem_be), 64'hF);
        for (int i = 0; i < lat; i++) begin
            @(posedge clk); @(negedge clk);
            chk(!done && busy && !mem_we, "R6", {tag, " waiting"}, 64'(done), 64'd0);
        end
        mem_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        mem_ready = 1'b0;
        chk(done == 1'b1, "R6", {tag, " done"}, 64'(done), 64'd1);
        chk(pc == pc0 + 64'd4, "R7", {tag, " pc"}, pc, pc0 + 64'd4);
        @(posedge clk); @(negedge clk);
        chk(!done && !busy, "R6", {tag, " done one cycle"}, 64'(done), 64'd0);
    endtask

    task automatic set_resv(input logic [31:0] a);
        @(negedge clk); resv_set = 1'b1; resv_addr = a;
        @(negedge clk); resv_set = 1'b0;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            summary();
            $finish;
        end
    end

    initial begin
        logic [63:0] pcs;
        int we0;
        for (int i = 0; i < 32; i++) rf[i] = 64'h0;
        rf[0] = 64'h0000_0000_0000_5555;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_we && !done && !busy && !illegal && !resv_valid, "R6", "reset outputs quiet",
            {mem_we, done, busy, illegal, resv_valid}, 64'd0);
        chk(pc == 64'h100, "R7", "reset pc", pc, 64'h100);

        // Vector table: address, byte reversal, wrap, base zero, unaligned, bit 0 ignored.
        for (int v = 0; v < 5; v++) begin
            rf[VEC[v].a] = (VEC[v].a == 5'd0) ? rf[0] : VEC[v].bv;
            rf[VEC[v].b] = VEC[v].iv;
            if (VEC[v].s != 5'd0) rf[VEC[v].s] = VEC[v].sv;
            @(negedge clk);
            insn_word = mk(VEC[v].s, VEC[v].a, VEC[v].b, VEC[v].rc);
            insn_valid = 1'b1; #1;
            chk(rf_src_addr == VEC[v].s && rf_idx_addr == VEC[v].b && rf_base_addr == VEC[v].a,
                "R2", "register selects", {49'd0, rf_src_addr, rf_base_addr, rf_idx_addr},
                {49'd0, VEC[v].s, VEC[v].a, VEC[v].b});
            chk(rf_base_re == (VEC[v].a != 5'd0), "R4", "base read enable",
                64'(rf_base_re), 64'(VEC[v].a != 5'd0));
            chk(!illegal, "R1", "store decoded", 64'(illegal), 64'd0);
            insn_valid = 1'b0;
            run_store(insn_word, int'(VEC[v].lat), VEC[v].ea, VEC[v].dat, $sformatf("vec%0d", v));
        end

        // R8: matching granule clears reservation.
        rf[4] = 64'h0; rf[5] = 64'h101C; rf[3] = 64'h1;
        resv_en = 1'b1;
        set_resv(32'h0000_1000);
        chk(resv_valid, "R8", "reservation set", 64'(resv_valid), 64'd1);
        @(negedge clk); insn_word = mk(5'd3, 5'd4, 5'd5, 1'b0); insn_valid = 1'b1;
        @(posedge clk); @(negedge clk); insn_valid = 1'b0;
        chk(!resv_valid && mem_we, "R8", "match clears with write", {resv_valid, mem_we}, 64'd1);
        mem_ready = 1'b1; @(posedge clk); @(negedge clk); mem_ready = 1'b0;

        // R8: next granule leaves it; R11 unaligned as well.
        set_resv(32'h0000_1000);
        rf[5] = 64'h1021;
        run_store(mk(5'd3, 5'd4, 5'd5, 1'b0), 0, 32'h0000_1021, 32'h0100_0000, "R11 unaligned");
        chk(resv_valid, "R8", "other granule keeps", 64'(resv_valid), 64'd1);

        // R8: tracking disabled keeps reservation.
        resv_en = 1'b0; rf[5] = 64'h1004;
        run_store(mk(5'd3, 5'd4, 5'd5, 1'b0), 0, 32'h0000_1004, 32'h0100_0000, "disabled");
        chk(resv_valid, "R8", "disabled keeps", 64'(resv_valid), 64'd1);

        // R9: foreign word.
        resv_en = 1'b1; rf[5] = 64'h1000;
        pcs = pc; we0 = n_we;
        @(negedge clk); insn_word = mk(5'd3, 5'd4, 5'd5, 1'b0) ^ 32'h0000_0040; insn_valid = 1'b1;
        @(posedge clk); @(negedge clk); insn_valid = 1'b0;
        chk(illegal && !mem_we && !busy, "R9", "illegal pulse no write", {illegal, mem_we, busy}, 64'h4);
        @(posedge clk); @(negedge clk);
        chk(!illegal, "R9", "illegal one cycle", 64'(illegal), 64'd0);
        chk(resv_valid && pc == pcs && n_we == we0, "R9", "no side effects", pc, pcs);
        @(negedge clk); insn_word = 32'h7800052C; insn_valid = 1'b1;
        @(posedge clk); @(negedge clk); insn_valid = 1'b0;
        chk(illegal, "R1", "wrong primary opcode rejected", 64'(illegal), 64'd1);

        // R10: words presented while pending are ignored.
        rf[5] = 64'h2000; pcs = pc; we0 = n_we;
        @(negedge clk); insn_word = mk(5'd3, 5'd4, 5'd5, 1'b0); insn_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        insn_word = 32'hFFFF_FFFF;
        @(posedge clk); @(negedge clk);
        chk(!illegal && busy, "R10", "foreign word ignored while pending", 64'(illegal), 64'd0);
        insn_word = mk(5'd3, 5'd0, 5'd5, 1'b0);
        @(posedge clk); @(negedge clk);
        chk(mem_addr == 32'h2000 && !mem_we, "R10", "store ignored while pending", 64'(mem_addr), 64'h2000);
        insn_valid = 1'b0; mem_ready = 1'b1;
        @(posedge clk); @(negedge clk); mem_ready = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(n_we == we0 + 1, "R10", "single write", 64'(n_we - we0), 64'd1);
        chk(pc == pcs + 64'd4, "R7", "single pc step", pc, pcs + 64'd4);

        finished = 1;
        summary();
        $finish;
    end
endmodule